// File: doc/BRIEF.md
# Constant-Latency Single-Precision Float Divider

This block divides one IEEE-754 single-precision operand (the dividend) by another (the divisor) and returns a correctly rounded single-precision quotient. Each operand and the result move over a strobe/acknowledge handshake of their own. A word moves on a rising clock edge where its strobe and acknowledge are both high. The block takes the dividend first, then the divisor, and then offers the result until the consumer acknowledges it.

The defining property is timing. The result strobe rises a fixed number of cycles after the divisor is accepted, whatever the operand values are. Special operands are classified and their result is stored together with a select flag, but they do not end the operation early. Every operation runs the same unpack, adjust, fixed-count normalisation, fixed-count restoring division, round and pack steps. At the packing step the flag chooses either the stored special word or the computed quotient. This closes the timing side channel that an early exit for zero, infinity or NaN operands would open.

Top module: `fpdiv_const_lat`

## Requirements
- R1: The dividend is accepted on an edge where `a_stb` and `a_ack` are both high. After that the block raises only `b_ack`. Once the divisor is accepted, `a_ack` and `b_ack` stay low until the result has been taken, and `a_ack` and `b_ack` are never high together.
- R2: If either operand is a NaN (exponent field 255 and fraction nonzero), the result is 0xFFC00000: sign 1, exponent 255, fraction bit 22 set and fraction bits 21:0 clear.
- R3: Infinity divided by infinity gives 0xFFC00000, and so does zero divided by zero. Infinity is exponent 255 with fraction 0, and zero is exponent 0 with fraction 0.
- R4: Infinity divided by any non-NaN value other than infinity (zero included) gives an infinity. A nonzero finite value divided by zero also gives an infinity. In both cases the sign is the XOR of the operand signs (bit 31), the exponent is 255 and the fraction is 0.
- R5: A finite value divided by infinity gives zero, and zero divided by a nonzero finite value gives zero. The sign is the XOR of the operand signs and bits 30:0 are zero.
- R6: For normal operands the result is the quotient rounded to nearest, ties to even, using guard, round and sticky bits (for example 1.0/3.0 = 0x3EAAAAAB).
- R7: A denormal operand (exponent field 0, fraction nonzero) uses exponent -126 with no hidden bit, and is normalised before division (for example 2^-149 / 2^-149 = 0x3F800000).
- R8: A result exponent above 127 after rounding gives a signed infinity. A result below the normal range is shifted into a denormal and rounded to nearest-even, which can give zero (for example 2^-149 / 2.0 = 0x00000000).
- R9: With the default parameters the result strobe rises exactly DIV_ITERS + NORM_STEPS + 6 = 80 clock edges after the edge that accepts the divisor, for every operand pair and for any gap between the two operands.
- R10: `z_stb` stays high with `z_word` unchanged until `z_ack` is seen. The block then returns to waiting for a dividend (`a_ack` high). Reset, even in the middle of an operation, also returns it to that state with `b_ack` and `z_stb` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| a_word | input | 32 | Dividend operand |
| a_stb | input | 1 | Dividend valid |
| a_ack | output | 1 | Dividend can be taken |
| b_word | input | 32 | Divisor operand |
| b_stb | input | 1 | Divisor valid |
| b_ack | output | 1 | Divisor can be taken |
| z_word | output | 32 | Quotient result |
| z_stb | output | 1 | Quotient valid |
| z_ack | input | 1 | Quotient taken by the consumer |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit fraction, 50 division iterations and 24 normalisation steps, which give an 80-cycle latency. Using the full normalisation count means the smallest denormal, which has 23 leading zeros, can be normalised completely. That brings the denormal-operand and ties-to-even underflow cases within reach, beside the special operand classes and overflow. The same fixed latency is measured for special, normal and denormal operands, and with gaps of different length between the dividend and the divisor.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

   typedef enum logic [3:0] {
      ST_TAKE_A,
      ST_TAKE_B,
      ST_UNPACK,
      ST_CLASSIFY,
      ST_NORMALISE,
      ST_DIVIDE,
      ST_QNORM,
      ST_DENORM,
      ST_ROUND,
      ST_PACK,
      ST_OFFER
   } fpdiv_state_e;

   typedef struct packed {
      logic is_nan;
      logic is_inf;
      logic is_zero;
   } fpdiv_class_t;

endpackage

// File: rtl/fpdiv_classify.sv
module fpdiv_classify
   import fpdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] dvd_word,
   input  logic [EXP_W+FRAC_W:0] dvs_word,
   output logic                  use_special,
   output logic [EXP_W+FRAC_W:0] special_word
);
   localparam int WW = 1 + EXP_W + FRAC_W;

   logic [WW-1:0] ops [2];
   fpdiv_class_t  cls [2];
   logic          sgn;

   assign ops[0] = dvd_word;
   assign ops[1] = dvs_word;

   // same classifier for both operands
   for (genvar gi = 0; gi < 2; gi++) begin : g_op
      logic exp_ones, exp_zero, frac_zero;
      assign exp_ones  = &ops[gi][FRAC_W +: EXP_W];
      assign exp_zero  = ~|ops[gi][FRAC_W +: EXP_W];
      assign frac_zero = ~|ops[gi][FRAC_W-1:0];
      assign cls[gi].is_nan  = exp_ones & ~frac_zero;
      assign cls[gi].is_inf  = exp_ones & frac_zero;
      assign cls[gi].is_zero = exp_zero & frac_zero;
   end

   assign sgn = dvd_word[WW-1] ^ dvs_word[WW-1];

   always_comb begin
      use_special  = 1'b1;
      special_word = '0;
      if (cls[0].is_nan || cls[1].is_nan ||
          (cls[0].is_inf && cls[1].is_inf) ||
          (cls[0].is_zero && cls[1].is_zero)) begin
         special_word = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      end else if (cls[0].is_inf || cls[1].is_zero) begin
         special_word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (cls[1].is_inf || cls[0].is_zero) begin
         special_word = {sgn, {(WW-1){1'b0}}};
      end else begin
         use_special = 1'b0;
      end
   end
endmodule

// File: rtl/fpdiv_denorm.sv
module fpdiv_denorm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W+2:0]        x_in,
   input  logic                     st_in,
   input  logic signed [EXP_W+1:0]  e_in,
   output logic [FRAC_W+2:0]        x_out,
   output logic                     st_out,
   output logic signed [EXP_W+1:0]  e_out
);
   localparam int XW   = FRAC_W + 3;
   localparam int SEW  = EXP_W + 2;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int SHW  = $clog2(XW + 1);
   localparam logic signed [SEW-1:0] E_MIN = SEW'(1 - BIAS);
   localparam logic signed [SEW-1:0] XW_S  = SEW'(XW);

   logic signed [SEW-1:0] diff;
   logic [SHW-1:0]        sh;
   logic [2*XW-1:0]       wide;

   assign diff = E_MIN - e_in;

   always_comb begin
      if (e_in >= E_MIN)      sh = '0;
      else if (diff > XW_S)   sh = SHW'(XW);
      else                    sh = SHW'(diff);
   end

   // a shift of zero passes the value through in the same time
   assign wide   = {x_in, {XW{1'b0}}} >> sh;
   assign x_out  = wide[2*XW-1:XW];
   assign st_out = st_in | (|wide[XW-1:0]);
   assign e_out  = (e_in < E_MIN) ? E_MIN : e_in;
endmodule

// File: rtl/fpdiv_round_pack.sv
module fpdiv_round_pack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W+2:0]        rx_in,
   input  logic                     rst_in,
   input  logic signed [EXP_W+1:0]  re_in,
   output logic [FRAC_W:0]          rm_out,
   output logic signed [EXP_W+1:0]  re_out,
   input  logic [FRAC_W:0]          pm_in,
   input  logic signed [EXP_W+1:0]  pe_in,
   input  logic                     ps_in,
   output logic [EXP_W+FRAC_W:0]    packed_word
);
   localparam int MW   = FRAC_W + 1;
   localparam int SEW  = EXP_W + 2;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [SEW-1:0] E_MAX = SEW'(BIAS);

   logic [MW-1:0] m;
   logic          g, r, up;
   logic [MW:0]   sum;
   logic [SEW-1:0] bexp;

   assign m   = rx_in[XWTOP():2];
   assign g   = rx_in[1];
   assign r   = rx_in[0];
   assign up  = g & (r | rst_in | m[0]);
   assign sum = {1'b0, m} + (MW+1)'(up);

   function automatic int XWTOP();
      return FRAC_W + 2;
   endfunction

   always_comb begin
      if (sum[MW]) begin
         rm_out = sum[MW:1];
         re_out = re_in + SEW'(1);
      end else begin
         rm_out = sum[MW-1:0];
         re_out = re_in;
      end
   end

   assign bexp = pe_in + SEW'(BIAS);

   always_comb begin
      if (pe_in > E_MAX)
         packed_word = {ps_in, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (!pm_in[MW-1])
         packed_word = {ps_in, {EXP_W{1'b0}}, pm_in[FRAC_W-1:0]};
      else
         packed_word = {ps_in, bexp[EXP_W-1:0], pm_in[FRAC_W-1:0]};
   end
endmodule

// File: rtl/fpdiv_const_lat.sv
module fpdiv_const_lat
   import fpdiv_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter int DIV_ITERS  = 50,
   parameter int NORM_STEPS = 24
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [EXP_W+FRAC_W:0] a_word,
   input  logic                  a_stb,
   output logic                  a_ack,
   input  logic [EXP_W+FRAC_W:0] b_word,
   input  logic                  b_stb,
   output logic                  b_ack,
   output logic [EXP_W+FRAC_W:0] z_word,
   output logic                  z_stb,
   input  logic                  z_ack
);
   localparam int WW   = 1 + EXP_W + FRAC_W;
   localparam int MW   = FRAC_W + 1;
   localparam int XW   = MW + 2;
   localparam int SEW  = EXP_W + 2;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int NCW  = $clog2(NORM_STEPS + 1);
   localparam int DCW  = $clog2(DIV_ITERS + 1);
   localparam logic signed [SEW-1:0] E_MIN = SEW'(1 - BIAS);
   localparam logic signed [SEW-1:0] E_DEN = SEW'(-BIAS);

   // elaboration-time parameter checks
   if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_fmt
      $error("fpdiv_const_lat: format too narrow");
   end
   if (NORM_STEPS < FRAC_W) begin : g_bad_norm
      $error("fpdiv_const_lat: NORM_STEPS must cover a full denormal");
   end
   if (DIV_ITERS < FRAC_W + 4) begin : g_bad_div
      $error("fpdiv_const_lat: DIV_ITERS too small for guard/round/sticky");
   end
   if (FRAC_W >= (1 << EXP_W)) begin : g_bad_range
      $error("fpdiv_const_lat: exponent range register too narrow");
   end

   fpdiv_state_e          state;
   logic [WW-1:0]         a_raw, b_raw, z_r, sp_word;
   logic                  sel_sp, z_s;
   logic [MW-1:0]         a_m, b_m;
   logic signed [SEW-1:0] a_e, b_e, z_e;
   logic [NCW-1:0]        ncnt;
   logic [DCW-1:0]        dcnt;
   logic [DIV_ITERS-1:0]  q;
   logic [MW:0]           rem;
   logic [XW-1:0]         dx;
   logic                  dst;
   logic signed [SEW-1:0] de;
   logic [MW-1:0]         rm;
   logic signed [SEW-1:0] re;

   // combinational helpers
   logic                  cls_sel;
   logic [WW-1:0]         cls_word;
   logic [MW-1:0]         a_m_nx, b_m_nx;
   logic signed [SEW-1:0] a_e_nx, b_e_nx;
   logic                  rem_ge;
   logic [MW:0]           rem_sub;
   logic [XW-1:0]         qx, dn_x;
   logic                  q_st, dn_st;
   logic signed [SEW-1:0] dn_e, rn_e;
   logic [MW-1:0]         rn_m;
   logic [WW-1:0]         pk_word;

   fpdiv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
      .dvd_word     (a_raw),
      .dvs_word     (b_raw),
      .use_special  (cls_sel),
      .special_word (cls_word)
   );

   assign a_m_nx = a_m[MW-1] ? a_m : {a_m[MW-2:0], 1'b0};
   assign a_e_nx = a_m[MW-1] ? a_e : a_e - SEW'(1);
   assign b_m_nx = b_m[MW-1] ? b_m : {b_m[MW-2:0], 1'b0};
   assign b_e_nx = b_m[MW-1] ? b_e : b_e - SEW'(1);

   assign rem_ge  = rem >= {1'b0, b_m};
   assign rem_sub = rem_ge ? rem - {1'b0, b_m} : rem;

   assign qx   = q[DIV_ITERS-1 -: XW];
   assign q_st = (|q[DIV_ITERS-1-XW:0]) | (|rem);

   fpdiv_denorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_denorm (
      .x_in   (qx),
      .st_in  (q_st),
      .e_in   (z_e),
      .x_out  (dn_x),
      .st_out (dn_st),
      .e_out  (dn_e)
   );

   fpdiv_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_round_pack (
      .rx_in       (dx),
      .rst_in      (dst),
      .re_in       (de),
      .rm_out      (rn_m),
      .re_out      (rn_e),
      .pm_in       (rm),
      .pe_in       (re),
      .ps_in       (z_s),
      .packed_word (pk_word)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state   <= ST_TAKE_A;
         a_raw   <= '0;
         b_raw   <= '0;
         z_r     <= '0;
         sp_word <= '0;
         sel_sp  <= 1'b0;
         z_s     <= 1'b0;
         a_m     <= '0;
         b_m     <= '0;
         a_e     <= '0;
         b_e     <= '0;
         z_e     <= '0;
         ncnt    <= '0;
         dcnt    <= '0;
         q       <= '0;
         rem     <= '0;
         dx      <= '0;
         dst     <= 1'b0;
         de      <= '0;
         rm      <= '0;
         re      <= '0;
      end else begin
         case (state)
            ST_TAKE_A: if (a_stb) begin
               a_raw <= a_word;
               state <= ST_TAKE_B;
            end
            ST_TAKE_B: if (b_stb) begin
               b_raw <= b_word;
               state <= ST_UNPACK;
            end
            ST_UNPACK: begin
               a_m   <= {1'b0, a_raw[FRAC_W-1:0]};
               b_m   <= {1'b0, b_raw[FRAC_W-1:0]};
               a_e   <= SEW'(a_raw[FRAC_W +: EXP_W]) - SEW'(BIAS);
               b_e   <= SEW'(b_raw[FRAC_W +: EXP_W]) - SEW'(BIAS);
               z_s   <= a_raw[WW-1] ^ b_raw[WW-1];
               state <= ST_CLASSIFY;
            end
            ST_CLASSIFY: begin
               sel_sp  <= cls_sel;
               sp_word <= cls_word;
               if (a_e == E_DEN) a_e <= E_MIN;
               else              a_m[MW-1] <= 1'b1;
               if (b_e == E_DEN) b_e <= E_MIN;
               else              b_m[MW-1] <= 1'b1;
               ncnt  <= '0;
               state <= ST_NORMALISE;
            end
            ST_NORMALISE: begin
               a_m  <= a_m_nx;
               a_e  <= a_e_nx;
               b_m  <= b_m_nx;
               b_e  <= b_e_nx;
               ncnt <= ncnt + NCW'(1);
               if (ncnt == NCW'(NORM_STEPS - 1)) begin
                  rem   <= {1'b0, a_m_nx};
                  z_e   <= a_e_nx - b_e_nx;
                  dcnt  <= '0;
                  state <= ST_DIVIDE;
               end
            end
            ST_DIVIDE: begin
               q    <= {q[DIV_ITERS-2:0], rem_ge};
               rem  <= {rem_sub[MW-1:0], 1'b0};
               dcnt <= dcnt + DCW'(1);
               if (dcnt == DCW'(DIV_ITERS - 1)) state <= ST_QNORM;
            end
            ST_QNORM: begin
               if (!q[DIV_ITERS-1]) begin
                  q   <= {q[DIV_ITERS-2:0], 1'b0};
                  z_e <= z_e - SEW'(1);
               end
               state <= ST_DENORM;
            end
            ST_DENORM: begin
               dx    <= dn_x;
               dst   <= dn_st;
               de    <= dn_e;
               state <= ST_ROUND;
            end
            ST_ROUND: begin
               rm    <= rn_m;
               re    <= rn_e;
               state <= ST_PACK;
            end
            ST_PACK: begin
               z_r   <= sel_sp ? sp_word : pk_word;
               state <= ST_OFFER;
            end
            ST_OFFER: if (z_ack) state <= ST_TAKE_A;
            default: state <= ST_TAKE_A;
         endcase
      end
   end

   assign a_ack  = (state == ST_TAKE_A);
   assign b_ack  = (state == ST_TAKE_B);
   assign z_stb  = (state == ST_OFFER);
   assign z_word = z_r;
endmodule

// File: rtl/fpdiv_const_lat_chk.sv
module fpdiv_const_lat_chk #(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter int DIV_ITERS  = 50,
   parameter int NORM_STEPS = 24
) (
   input logic                  clk,
   input logic                  rst,
   input logic [EXP_W+FRAC_W:0] a_word,
   input logic                  a_stb,
   input logic                  a_ack,
   input logic [EXP_W+FRAC_W:0] b_word,
   input logic                  b_stb,
   input logic                  b_ack,
   input logic [EXP_W+FRAC_W:0] z_word,
   input logic                  z_stb,
   input logic                  z_ack
);
   localparam int WW  = 1 + EXP_W + FRAC_W;
   localparam int LAT = DIV_ITERS + NORM_STEPS + 6;
   localparam logic [WW-1:0] QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [WW-1:0] cap_a, cap_b;
   logic          busy;
   int unsigned   lat_cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cap_a   <= '0;
         cap_b   <= '0;
         busy    <= 1'b0;
         lat_cnt <= 0;
      end else begin
         if (a_stb && a_ack) cap_a <= a_word;
         if (b_stb && b_ack) begin
            cap_b   <= b_word;
            busy    <= 1'b1;
            lat_cnt <= 0;
         end else if (busy) begin
            lat_cnt <= lat_cnt + 1;
            if (z_stb) busy <= 1'b0;
         end
      end
   end

   logic a_nan, b_nan, a_inf, b_inf;
   assign a_nan = (&cap_a[FRAC_W +: EXP_W]) && (|cap_a[FRAC_W-1:0]);
   assign b_nan = (&cap_b[FRAC_W +: EXP_W]) && (|cap_b[FRAC_W-1:0]);
   assign a_inf = (&cap_a[FRAC_W +: EXP_W]) && !(|cap_a[FRAC_W-1:0]);
   assign b_inf = (&cap_b[FRAC_W +: EXP_W]) && !(|cap_b[FRAC_W-1:0]);

   p_one_ack_r1: assert property (@(posedge clk) disable iff (rst)
      !(a_ack && b_ack));

   p_quiet_offer_r1: assert property (@(posedge clk) disable iff (rst)
      z_stb |-> (!a_ack && !b_ack));

   p_nan_r2: assert property (@(posedge clk) disable iff (rst)
      (z_stb && (a_nan || b_nan)) |-> (z_word == QNAN));

   p_inf_num_r4: assert property (@(posedge clk) disable iff (rst)
      (z_stb && a_inf && !b_inf && !b_nan) |->
         (z_word == {cap_a[WW-1] ^ cap_b[WW-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

   p_latency_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(z_stb) |-> (busy && lat_cnt == LAT));

   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (z_stb && !z_ack) |=> (z_stb && $stable(z_word)));

   p_release_r10: assert property (@(posedge clk) disable iff (rst)
      (z_stb && z_ack) |=> (a_ack && !z_stb));
endmodule

bind fpdiv_const_lat fpdiv_const_lat_chk #(
   .EXP_W      (EXP_W),
   .FRAC_W     (FRAC_W),
   .DIV_ITERS  (DIV_ITERS),
   .NORM_STEPS (NORM_STEPS)
) i_chk (
   .clk    (clk),
   .rst    (rst),
   .a_word (a_word),
   .a_stb  (a_stb),
   .a_ack  (a_ack),
   .b_word (b_word),
   .b_stb  (b_stb),
   .b_ack  (b_ack),
   .z_word (z_word),
   .z_stb  (z_stb),
   .z_ack  (z_ack)
);

// File: tb/test_fpdiv_const_lat.sv
module test_fpdiv_const_lat;
   localparam int NV       = 23;
   localparam int EXP_LAT  = 80;      // R9: 50 + 24 + 6 with defaults
   localparam int WDOG_MAX = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a_word = '0, b_word = '0;
   logic        a_stb = 1'b0, b_stb = 1'b0, z_ack = 1'b0;
   logic        a_ack, b_ack, z_stb;
   logic [31:0] z_word;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   fpdiv_const_lat i_fpdiv_const_lat (
      .clk(clk), .rst(rst),
      .a_word(a_word), .a_stb(a_stb), .a_ack(a_ack),
      .b_word(b_word), .b_stb(b_stb), .b_ack(b_ack),
      .z_word(z_word), .z_stb(z_stb), .z_ack(z_ack)
   );

   // {dividend, divisor, expected quotient, requirement number}
   localparam logic [99:0] VEC [NV] = '{
      {32'h40C00000, 32'h40000000, 32'h40400000, 4'd6},  // R6 6/2
      {32'h3F800000, 32'h40400000, 32'h3EAAAAAB, 4'd6},  // R6 1/3
      {32'h40000000, 32'h40400000, 32'h3F2AAAAB, 4'd6},  // R6 2/3
      {32'hBF800000, 32'h40000000, 32'hBF000000, 4'd6},  // R6 -1/2
      {32'h41200000, 32'h40A00000, 32'h40000000, 4'd6},  // R6 10/5
      {32'h3F800000, 32'h00000000, 32'h7F800000, 4'd4},  // R4 1/0
      {32'hBF800000, 32'h00000000, 32'hFF800000, 4'd4},  // R4 -1/0
      {32'h7F800000, 32'hC0000000, 32'hFF800000, 4'd4},  // R4 inf/-2
      {32'h7F800000, 32'h00000000, 32'h7F800000, 4'd4},  // R4 inf/0
      {32'h00000000, 32'h00000000, 32'hFFC00000, 4'd3},  // R3 0/0
      {32'h7F800000, 32'hFF800000, 32'hFFC00000, 4'd3},  // R3 inf/inf
      {32'h7FC00000, 32'h3F800000, 32'hFFC00000, 4'd2},  // R2 NaN/1
      {32'h3F800000, 32'hFF812345, 32'hFFC00000, 4'd2},  // R2 1/NaN
      {32'h40400000, 32'h7F800000, 32'h00000000, 4'd5},  // R5 3/inf
      {32'hC0400000, 32'h7F800000, 32'h80000000, 4'd5},  // R5 -3/inf
      {32'h80000000, 32'h40A00000, 32'h80000000, 4'd5},  // R5 -0/5
      {32'h00000000, 32'h7F800000, 32'h00000000, 4'd5},  // R5 0/inf
      {32'h00000001, 32'h00000001, 32'h3F800000, 4'd7},  // R7 dn/dn
      {32'h00000001, 32'h3F000000, 32'h00000002, 4'd7},  // R7 dn/0.5
      {32'h7F7FFFFF, 32'h3F000000, 32'h7F800000, 4'd8},  // R8 overflow
      {32'h00800000, 32'h40000000, 32'h00400000, 4'd8},  // R8 to denormal
      {32'h00000001, 32'h40000000, 32'h00000000, 4'd8},  // R8 tie to zero
      {32'h00000003, 32'h40000000, 32'h00000002, 4'd8}   // R8 tie up to even
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_neg_until_ack(input bit which_b);
      int guard = 0;
      while ((which_b ? b_ack : a_ack) !== 1'b1 && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic run_vec(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_z, input int req, input int gap);
      int lat;
      bit quiet;
      logic [31:0] held;
      string rq;
      rq = $sformatf("R%0d", req);
      @(negedge clk);
      a_word = a; a_stb = 1'b1;
      wait_neg_until_ack(1'b0);
      @(posedge clk);
      @(negedge clk);
      a_stb = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      b_word = b; b_stb = 1'b1;
      wait_neg_until_ack(1'b1);
      @(posedge clk);                       // divisor accepted here
      lat = 0;
      quiet = 1'b1;
      while (lat < 400) begin
         @(negedge clk);
         b_stb = 1'b0;
         if (z_stb) break;
         if (a_ack || b_ack) quiet = 1'b0;
         lat++;
      end
      check(quiet, "R1", "acks low during compute", 32'(a_ack), 32'd0);
      check(lat == EXP_LAT, "R9", "latency", 32'(lat), 32'(EXP_LAT));
      check(z_word === exp_z, rq, "quotient", z_word, exp_z);
      held = z_word;
      for (int h = 0; h < 3; h++) @(negedge clk);
      check(z_stb === 1'b1 && z_word === held, "R10", "hold until ack",
            z_word, held);
      z_ack = 1'b1;
      @(negedge clk);
      z_ack = 1'b0;
      check(z_stb === 1'b0 && a_ack === 1'b1, "R10", "release to take A",
            {30'd0, z_stb, a_ack}, 32'd1);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_MAX) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG_MAX);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(a_ack === 1'b1 && b_ack === 1'b0 && z_stb === 1'b0, "R10",
            "reset state", {29'd0, a_ack, b_ack, z_stb}, 32'd4);
      rst = 1'b0;
      @(negedge clk);
      check(a_ack === 1'b1 && b_ack === 1'b0 && z_stb === 1'b0, "R1",
            "idle after reset", {29'd0, a_ack, b_ack, z_stb}, 32'd4);

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i][99:68], VEC[i][67:36], VEC[i][35:4],
                 int'(VEC[i][3:0]), i % 3);
      end

      // R10 reset in the middle of an operation
      @(negedge clk);
      a_word = 32'h40C00000; a_stb = 1'b1;
      wait_neg_until_ack(1'b0);
      @(posedge clk);
      @(negedge clk);
      a_stb = 1'b0;
      check(b_ack === 1'b1 && a_ack === 1'b0, "R1", "divisor stage after A",
            {30'd0, a_ack, b_ack}, 32'd1);
      b_word = 32'h40000000; b_stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      b_stb = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(a_ack === 1'b1 && b_ack === 1'b0 && z_stb === 1'b0, "R10",
            "mid-operation reset", {29'd0, a_ack, b_ack, z_stb}, 32'd4);

      // R9 long gap between operands, then R6 result after reset
      run_vec(32'h3F800000, 32'h40400000, 32'h3EAAAAAB, 6, 7);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule